// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block is the digital heart of a center-spread clock modulator. It runs on the reference clock and produces a signed frequency-offset word that a fractional feedback divider would add to its nominal ratio. The word sweeps the synthesized clock evenly above and below the reference. The sweep is a linear triangle: it starts at zero, climbs to the positive peak, falls through zero to the negative peak, and climbs back to zero at the end of each modulation period. A one-cycle strobe marks the first clock of every period.

The control inputs pass through a two-flop synchronizer. They are an active-low spread enable, a rate bit and two range bits. The rate bit sets the period to 1280 or 3840 reference cycles. The rate bit and the range bits together select one of eight peak amplitudes. A new selection takes effect only when a period begins and the offset is zero. When the enable goes high, the sweep stops and the offset goes to zero. When the enable returns low, the sweep restarts from the start of a period.

The sequencing is done by a five-state machine:
- `ST_IDLE`: spreading is off and the output is zero.
- `ST_UP_POS`: the magnitude rises and the sign is positive.
- `ST_DN_POS`: the magnitude falls and the sign is positive.
- `ST_UP_NEG`: the magnitude rises and the sign is negative.
- `ST_DN_NEG`: the magnitude falls and the sign is negative.

The transitions are:
- `ST_IDLE` goes to `ST_UP_POS` when the synchronized enable is active. This transition latches the code.
- `ST_UP_POS` goes to `ST_DN_POS` at the peak.
- `ST_DN_POS` goes to `ST_UP_NEG` after the zero crossing.
- `ST_UP_NEG` goes to `ST_DN_NEG` at the negative peak.
- `ST_DN_NEG` goes to `ST_UP_POS` at the end of the period. This transition latches the code again and raises the strobe.
- Every running state goes to `ST_IDLE` when the synchronized enable is inactive.

Top module: `ssc_profile_gen`

## Requirements
- R1: While the synchronized enable is inactive, `freq_offset` is 0 and `period_start` is 0. After `spread_en_n` rises, the sweep continues for the clock edges at which the synchronizer fills. The output reads zero from the third rising edge onward.
- R2: After `spread_en_n` falls while the block is idle, `period_start` is first 1 after the third rising clock edge.
- R3: The 3-bit code is {`rate_sel`, `range_sel[1]`, `range_sel[0]`}. The peak (half-spread) magnitudes are in units of 2^-20 of the nominal ratio, rounded to nearest. For codes 0 to 7 they are 6291, 9961, 4719, 7864, 6816, 11010, 6816 and 11010. These correspond to total spreads of 1.2, 1.9, 0.9, 1.5, 1.3, 2.1, 1.3 and 2.1 percent.
- R4: The modulation period is N = 1280 clocks when the code's rate bit is 0 and N = 3840 when it is 1. Successive strobes are exactly N clocks apart.
- R5: With Q = N/4 and peak P, the offset at phase p (0 ≤ p < N) is sign·floor(P·k/Q). For p ≤ Q the value is +k with k = p. For p ≤ 2Q it is +k with k = 2Q−p. For p ≤ 3Q it is −k with k = p−2Q. Otherwise it is −k with k = N−p.
- R6: `period_start` is high for exactly one clock, at phase 0 of every period while spreading, and `freq_offset` is 0 in that clock.
- R7: A code change on the select inputs during a period leaves that period unchanged. The new code applies from the next phase 0.
- R8: When the enable is reasserted after a stop, the sweep restarts at phase 0 with the code currently on the inputs, whatever phase it was stopped at.
- R9: A synchronous active-high `rst` puts the block idle, with `freq_offset` 0 and `period_start` 0.
- R10: While running, the offset magnitude changes between consecutive clocks by at most floor(P/Q)+1 and never exceeds P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en_n | input | 1 | Spread enable, active low |
| rate_sel | input | 1 | Modulation rate select, code bit 2 |
| range_sel | input | 2 | Spread range select, code bits 1:0 |
| freq_offset | output | OFS_W (16) | Signed offset in units of 2^-20 |
| period_start | output | 1 | One-cycle strobe at phase 0 |

## Verification
The embedded assertions check several properties on every cycle:
- The disabled output is zero (R1).
- The strobe coincides with a zero offset (R6).
- The active code changes only on a strobe (R7).
- The quarter counter stays in range.
- The per-clock step and the peak bound hold (R10).

The exact triangle values, the period lengths for every code, the three-edge synchronizer latency and the restart at phase 0 after a stop can only be shown by the bench scenarios. These compare every clock of a full period against the arithmetic formula for all eight codes.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_POS,
        ST_DN_POS,
        ST_UP_NEG,
        ST_DN_NEG
    } ssc_state_e;

    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_UP,
        ACC_DOWN,
        ACC_CLEAR
    } acc_cmd_e;

    // Peak magnitude per code, units of 2^-20 of the nominal ratio
    function automatic int half_spread(input int code);
        case (code)
            0:       return 6291;
            1:       return 9961;
            2:       return 4719;
            3:       return 7864;
            4:       return 6816;
            5:       return 11010;
            6:       return 6816;
            7:       return 11010;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ssc_step_table.sv
module ssc_step_table #(
    parameter int Q_FAST = 320,
    parameter int Q_SLOW = 960,
    parameter int OFS_W  = 16,
    parameter int KW     = 10
) (
    input  logic [2:0]       code,
    output logic [OFS_W-1:0] step_int,
    output logic [KW-1:0]    step_rem,
    output logic [KW-1:0]    quarter
);
    logic [OFS_W-1:0] si_tab [8];
    logic [KW-1:0]    sr_tab [8];

    for (genvar g = 0; g < 8; g++) begin : g_entry
        localparam int PK = ssc_pkg::half_spread(g);
        localparam int QG = (g >= 4) ? Q_SLOW : Q_FAST;
        assign si_tab[g] = OFS_W'(PK / QG);
        assign sr_tab[g] = KW'(PK % QG);
    end

    assign step_int = si_tab[code];
    assign step_rem = sr_tab[code];
    assign quarter  = code[2] ? KW'(Q_SLOW) : KW'(Q_FAST);
endmodule

// File: rtl/ssc_ramp_acc.sv
module ssc_ramp_acc
    import ssc_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int KW    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_cmd_e         cmd,
    input  logic [OFS_W-1:0] step_int,
    input  logic [KW-1:0]    step_rem,
    input  logic [KW-1:0]    quarter,
    output logic [OFS_W-1:0] mag
);
    logic [OFS_W-1:0] mag_n;
    logic [KW-1:0]    rem_q, rem_n;
    logic [KW:0]      sum;

    always_comb begin
        sum   = {1'b0, rem_q} + {1'b0, step_rem};
        mag_n = mag;
        rem_n = rem_q;
        unique case (cmd)
            ACC_UP: begin
                if (sum >= {1'b0, quarter}) begin
                    rem_n = KW'(sum - {1'b0, quarter});
                    mag_n = mag + step_int + OFS_W'(1);
                end else begin
                    rem_n = KW'(sum);
                    mag_n = mag + step_int;
                end
            end
            ACC_DOWN: begin
                if (rem_q >= step_rem) begin
                    rem_n = rem_q - step_rem;
                    mag_n = mag - step_int;
                end else begin
                    rem_n = rem_q + quarter - step_rem;
                    mag_n = mag - step_int - OFS_W'(1);
                end
            end
            ACC_CLEAR: begin
                rem_n = '0;
                mag_n = '0;
            end
            default: begin
                rem_n = rem_q;
                mag_n = mag;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag   <= '0;
            rem_q <= '0;
        end else begin
            mag   <= mag_n;
            rem_q <= rem_n;
        end
    end

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (cmd == ACC_UP || cmd == ACC_DOWN) |=>
            (int'(mag) <= int'($past(mag)) + int'($past(step_int)) + 1) &&
            (int'(mag) + int'($past(step_int)) + 1 >= int'($past(mag)))); // R10

    AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cmd != ACC_CLEAR) |=>
            int'(mag) <= int'($past(step_int)) * int'($past(quarter)) + int'($past(step_rem))); // R10
endmodule

// File: rtl/ssc_phase_fsm.sv
module ssc_phase_fsm
    import ssc_pkg::*;
#(
    parameter int KW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [2:0]    code_in,
    input  logic [KW-1:0] quarter,
    output acc_cmd_e      cmd,
    output logic [2:0]    code_act,
    output logic          negative,
    output logic          strobe
);
    ssc_state_e    state_q, state_n;
    logic [KW-1:0] k_q, k_n;
    logic [2:0]    code_q, code_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_n;
            k_q     <= k_n;
            code_q  <= code_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        k_n     = k_q;
        code_n  = code_q;
        cmd     = ACC_HOLD;
        if (!run) begin
            state_n = ST_IDLE;
            k_n     = '0;
            cmd     = ACC_CLEAR;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n = ST_UP_POS;
                    k_n     = '0;
                    cmd     = ACC_CLEAR;
                    code_n  = code_in;
                end
                ST_UP_POS: begin
                    if (k_q == quarter) begin
                        state_n = ST_DN_POS;
                        k_n     = k_q - KW'(1);
                        cmd     = ACC_DOWN;
                    end else begin
                        k_n = k_q + KW'(1);
                        cmd = ACC_UP;
                    end
                end
                ST_DN_POS: begin
                    if (k_q == '0) begin
                        state_n = ST_UP_NEG;
                        k_n     = KW'(1);
                        cmd     = ACC_UP;
                    end else begin
                        k_n = k_q - KW'(1);
                        cmd = ACC_DOWN;
                    end
                end
                ST_UP_NEG: begin
                    if (k_q == quarter) begin
                        state_n = ST_DN_NEG;
                        k_n     = k_q - KW'(1);
                        cmd     = ACC_DOWN;
                    end else begin
                        k_n = k_q + KW'(1);
                        cmd = ACC_UP;
                    end
                end
                ST_DN_NEG: begin
                    if (k_q == KW'(1)) begin
                        state_n = ST_UP_POS;
                        k_n     = '0;
                        cmd     = ACC_CLEAR;
                        code_n  = code_in;
                    end else begin
                        k_n = k_q - KW'(1);
                        cmd = ACC_DOWN;
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    k_n     = '0;
                    cmd     = ACC_CLEAR;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        code_act = code_q;
        negative = (state_q == ST_UP_NEG) || (state_q == ST_DN_NEG);
        strobe   = (state_q == ST_UP_POS) && (k_q == '0);
    end

    AST_QUARTER_RANGE: assert property (@(posedge clk) disable iff (rst)
        k_q <= quarter); // R5

    AST_CODE_AT_START: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> strobe); // R7
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int PERIOD_FAST = 1280,
    parameter int PERIOD_SLOW = 3840,
    parameter int OFS_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spread_en_n,
    input  logic                    rate_sel,
    input  logic [1:0]              range_sel,
    output logic signed [OFS_W-1:0] freq_offset,
    output logic                    period_start
);
    localparam int Q_FAST = PERIOD_FAST / 4;
    localparam int Q_SLOW = PERIOD_SLOW / 4;
    localparam int KW     = $clog2(Q_SLOW + 1);

    logic [3:0]       ctl_s;
    logic             run;
    acc_cmd_e         cmd;
    logic [2:0]       code_act;
    logic             negative;
    logic [OFS_W-1:0] step_int, mag;
    logic [KW-1:0]    step_rem, quarter;

    ssc_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spread_en_n, rate_sel, range_sel}),
        .q   (ctl_s)
    );

    assign run = !ctl_s[3];

    ssc_phase_fsm #(.KW(KW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .code_in  (ctl_s[2:0]),
        .quarter  (quarter),
        .cmd      (cmd),
        .code_act (code_act),
        .negative (negative),
        .strobe   (period_start)
    );

    ssc_step_table #(.Q_FAST(Q_FAST), .Q_SLOW(Q_SLOW), .OFS_W(OFS_W), .KW(KW)) u_tab (
        .code     (code_act),
        .step_int (step_int),
        .step_rem (step_rem),
        .quarter  (quarter)
    );

    ssc_ramp_acc #(.OFS_W(OFS_W), .KW(KW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .step_int (step_int),
        .step_rem (step_rem),
        .quarter  (quarter),
        .mag      (mag)
    );

    assign freq_offset = negative ? -$signed(mag) : $signed(mag);

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> (freq_offset == '0) && !period_start); // R1

    AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        period_start |-> (freq_offset == '0)); // R6
endmodule

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spread_en_n = 1'b1;
    logic        rate_sel = 1'b0;
    logic [1:0]  range_sel = 2'b00;
    logic signed [15:0] freq_offset;
    logic        period_start;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ssc_profile_gen u0 (
        .clk          (clk),
        .rst          (rst),
        .spread_en_n  (spread_en_n),
        .rate_sel     (rate_sel),
        .range_sel    (range_sel),
        .freq_offset  (freq_offset),
        .period_start (period_start)
    );

    function automatic int peak_of(input int code);
        int tenths [8] = '{12, 19, 9, 15, 13, 21, 13, 21};
        return (tenths[code] * 1048576 + 1000) / 2000;
    endfunction

    function automatic int period_of(input int code);
        return (code >= 4) ? 3840 : 1280;
    endfunction

    function automatic int expect_ofs(input int code, input int p);
        int q, k, s;
        q = period_of(code) / 4;
        if (p <= q)          begin k = p;         s = 1;  end
        else if (p <= 2 * q) begin k = 2 * q - p; s = 1;  end
        else if (p <= 3 * q) begin k = p - 2 * q; s = -1; end
        else                 begin k = 4 * q - p; s = -1; end
        return s * ((peak_of(code) * k) / q);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R3 R4 R5 R6: compare cnt samples starting at phase p0
    task automatic check_span(input int code, input int p0, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            int p = p0 + i;
            chk("R5 offset", int'(freq_offset), expect_ofs(code, p));
            chk("R6 strobe", int'(period_start), (p == 0) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic set_code(input int code);
        rate_sel  = code[2];
        range_sel = code[1:0];
    endtask

    // R2: enable low, strobe appears after the third rising edge
    task automatic start_sweep();
        spread_en_n = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R2 strobe latency", int'(period_start), 0);
        end
        @(negedge clk);
        chk("R2 strobe latency", int'(period_start), 1);
    endtask

    initial begin
        #(150000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R9 reset offset", int'(freq_offset), 0);
        chk("R9 reset strobe", int'(period_start), 0);
        rst = 1'b0;

        // R1: disabled keeps output at zero
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R1 idle offset", int'(freq_offset), 0);
            chk("R1 idle strobe", int'(period_start), 0);
        end

        // R3 R4 R5 R7: all eight codes, each changed mid-period
        set_code(0);
        start_sweep();
        for (int c = 0; c < 8; c++) begin
            if (c < 7) begin
                check_span(c, 0, 100);
                set_code(c + 1);            // R7: must not affect this period
                check_span(c, 100, period_of(c) - 100);
            end else begin
                check_span(c, 0, 2500);
            end
        end

        // R1: stop in the negative half; output continues for 3 samples, then zero
        spread_en_n = 1'b1;
        set_code(5);
        check_span(7, 2500, 3);
        for (int i = 0; i < 40; i++) begin
            chk("R1 stopped offset", int'(freq_offset), 0);
            chk("R1 stopped strobe", int'(period_start), 0);
            @(negedge clk);
        end

        // R8: restart from phase 0 with the new code, two full periods
        start_sweep();
        check_span(5, 0, period_of(5));
        check_span(5, 0, period_of(5));

        // R1 R8: stop early in the rising half, restart at fast rate
        check_span(5, 0, 50);
        spread_en_n = 1'b1;
        set_code(2);
        check_span(5, 50, 3);
        chk("R1 stopped offset", int'(freq_offset), 0);
        start_sweep();
        check_span(2, 0, period_of(2));

        // R9: reset during sweep
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset offset", int'(freq_offset), 0);
        chk("R9 reset strobe", int'(period_start), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule